// File: doc/BRIEF.md
# Bus Initiator Phase Sequencer with Parking

This block runs the initiator side of a 32-bit multiplexed address/data bus in the PCI style. An internal client gives it one transfer at a time: a start address, a bus command, active-low byte enables, a burst length and a direction. Once the grant input is low, the block accepts the transfer and drives an address phase. It then runs as many data phases as the length asks for, and frames the burst on FRAME#. Write words are pulled from a FIFO through a pop strobe. Read words are captured from the bus and returned with a valid strobe.

A configuration input reverses the four bytes of every word that passes between the FIFO and the bus, in both directions. The byte enables are never touched by this reversal. When the grant arrives and no request is waiting, the block parks on the bus. It drives the address/data lines to zero and the command/enable lines to a fixed code, followed by the matching parity. It lets go of the bus one clock after the grant is withdrawn.

Every output is a register updated on the rising clock edge. The accept and pop strobes are the only outputs that depend combinationally on the inputs.

Top module: `pci_init_seq`

## Requirements
- R1: A request is accepted (`req_ready` high together with `req_valid`) only on a clock where the block is idle or parked and `gnt_n` is low. No request is accepted in any other state.
- R2: In the clock after acceptance, the block drives the address phase. AD carries the request address with bits 1:0 forced to 00. C/BE# carries the command. FRAME# is driven low. AD, C/BE# and FRAME# are all enabled.
- R3: In every data phase, C/BE# carries the request's active-low byte enables, where bit 0 covers AD[7:0]. On writes AD is driven with the current FIFO word. On reads the AD enable is off.
- R4: FRAME# stays low through every data phase except the final one, where it is high. In the clock after the final phase completes, AD, C/BE# and FRAME# are all released.
- R5: A data phase completes only at a clock edge where `trdy_n` and `devsel_n` are both low. On writes, `wr_pop` is high in the address-phase clock and in every completing clock except the final one.
- R6: With `cfg_big_endian` high, word bytes are reversed (byte 0 to byte 3, byte 1 to byte 2) on both the write path and the read path. With it low, words pass unchanged. The byte enables never depend on this input.
- R7: One clock after a read data phase completes, `rd_valid` is high and `rd_data` holds the word sampled from `ad_i` at that edge.
- R8: After every clock in which AD is enabled, the next clock has `par_oe` high and `par_o` equal to the XOR of the previous clock's AD and C/BE#. After a clock without AD enabled, `par_oe` is low.
- R9: When the block is idle, `gnt_n` is low and no request is valid, the block parks from the next clock. AD is 0, C/BE# equals `PARK_CBE` (default 4'b0000), both are enabled and FRAME# is not driven. A request that arrives while parked with the grant still low is accepted directly.
- R10: While parked, sampling `gnt_n` high releases AD and C/BE# in the following clock.
- R11: After reset, all output enables are low, FRAME# is high, `rd_valid` is low and `req_ready` follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted this clock |
| req_addr | input | 32 | Start byte address |
| req_cmd | input | 4 | Bus command for the address phase |
| req_be_n | input | 4 | Active-low byte enables for the data phases |
| req_len | input | LEN_W | Number of data phases, 1 to MAX_BURST |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_big_endian | input | 1 | Reverse bytes of FIFO data |
| wr_data | input | 32 | Head word of the write FIFO |
| wr_pop | output | 1 | Head word consumed at this edge |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | `rd_data` is new |
| gnt_n | input | 1 | Bus grant, active low |
| devsel_n | input | 1 | Target selected, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| ad_o | output | 32 | Address/data drive value |
| ad_oe | output | 1 | Address/data drive enable |
| cbe_o | output | 4 | Command/byte-enable drive value |
| cbe_oe | output | 1 | Command/byte-enable drive enable |
| par_o | output | 1 | Parity drive value |
| par_oe | output | 1 | Parity drive enable |
| frame_o | output | 1 | FRAME# drive value |
| frame_oe | output | 1 | FRAME# drive enable |

## Verification
The bench builds the block with `MAX_BURST` set to 4, so a burst at the full length is cheap to reach. It runs single-phase and full-length bursts in both directions, with wait states from both `trdy_n` and `devsel_n`. `PARK_CBE` keeps its default of 4'b0000. The parking code and its parity are therefore checked against an all-zero bus, and acceptance straight out of parking is also exercised.

// File: rtl/pci_seq_pkg.sv
package pci_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PARK = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic [3:0]  be_n;
        logic        write;
    } xfer_t;

    function automatic logic [31:0] lane_swap(input logic [31:0] w, input logic en);
        return en ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    endfunction

    function automatic logic even_par(input logic [31:0] d, input logic [3:0] c);
        return ^{d, c};
    endfunction

endpackage

// File: rtl/pci_phase_fsm.sv
module pci_phase_fsm
    import pci_seq_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gnt_n,
    input  logic             trdy_n,
    input  logic             devsel_n,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    output logic             accept,
    output logic             advance,
    output seq_st_e          st_q,
    output seq_st_e          st_d,
    output logic [LEN_W-1:0] cnt_q,
    output logic [LEN_W-1:0] cnt_d
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    always_comb begin
        req_ready = ((st_q == ST_IDLE) || (st_q == ST_PARK)) && !gnt_n;
        accept    = req_ready && req_valid;
        advance   = (st_q == ST_DATA) && !trdy_n && !devsel_n;
        st_d      = st_q;
        cnt_d     = cnt_q;
        if (accept) begin
            st_d  = ST_ADDR;
            cnt_d = req_len;
        end else begin
            unique case (st_q)
                ST_IDLE: if (!gnt_n) st_d = ST_PARK;
                ST_PARK: if (gnt_n)  st_d = ST_IDLE;
                ST_ADDR: st_d = ST_DATA;
                ST_DATA: begin
                    if (advance) begin
                        if (cnt_q == ONE) st_d = ST_IDLE;
                        else              cnt_d = cnt_q - ONE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // R1: no acceptance outside idle or park
    p_accept_state_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ADDR || st_q == ST_DATA) |-> !accept);

endmodule

// File: rtl/pci_lane_drv.sv
module pci_lane_drv
    import pci_seq_pkg::*;
#(
    parameter int          LEN_W    = 5,
    parameter logic [3:0]  PARK_CBE = 4'b0000
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_st_e          st_d,
    input  logic             accept,
    input  xfer_t            req,
    input  logic [LEN_W-1:0] cnt_d,
    input  logic             load,
    input  logic             advance,
    input  logic             big,
    input  logic [31:0]      wr_data,
    input  logic [31:0]      ad_i,
    output logic             write_q,
    output logic [31:0]      ad_o,
    output logic             ad_oe,
    output logic [3:0]       cbe_o,
    output logic             cbe_oe,
    output logic             par_o,
    output logic             par_oe,
    output logic             frame_o,
    output logic             frame_oe,
    output logic [31:0]      rd_data,
    output logic             rd_valid
);

    logic [3:0] be_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            write_q  <= 1'b0;
            be_q     <= 4'hF;
            ad_o     <= '0;
            ad_oe    <= 1'b0;
            cbe_o    <= '0;
            cbe_oe   <= 1'b0;
            frame_o  <= 1'b1;
            frame_oe <= 1'b0;
            par_o    <= 1'b0;
            par_oe   <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            par_o    <= even_par(ad_o, cbe_o);
            par_oe   <= ad_oe;
            rd_valid <= advance && !write_q;
            if (advance && !write_q) rd_data <= lane_swap(ad_i, big);
            if (accept) begin
                write_q <= req.write;
                be_q    <= req.be_n;
            end
            unique case (st_d)
                ST_ADDR: begin
                    ad_o     <= req.addr & ~32'h3;
                    cbe_o    <= req.cmd;
                    ad_oe    <= 1'b1;
                    cbe_oe   <= 1'b1;
                    frame_o  <= 1'b0;
                    frame_oe <= 1'b1;
                end
                ST_DATA: begin
                    if (load) ad_o <= lane_swap(wr_data, big);
                    cbe_o    <= be_q;
                    ad_oe    <= write_q;
                    cbe_oe   <= 1'b1;
                    frame_o  <= (cnt_d == LEN_W'(1));
                    frame_oe <= 1'b1;
                end
                ST_PARK: begin
                    ad_o     <= '0;
                    cbe_o    <= PARK_CBE;
                    ad_oe    <= 1'b1;
                    cbe_oe   <= 1'b1;
                    frame_o  <= 1'b1;
                    frame_oe <= 1'b0;
                end
                default: begin
                    ad_oe    <= 1'b0;
                    cbe_oe   <= 1'b0;
                    frame_o  <= 1'b1;
                    frame_oe <= 1'b0;
                end
            endcase
        end
    end

    // R8: parity enable trails the AD enable by one clock
    p_par_follow_r8: assert property (@(posedge clk) disable iff (rst)
        ad_oe |=> par_oe);
    p_par_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !ad_oe |=> !par_oe);

endmodule

// File: rtl/pci_init_seq.sv
module pci_init_seq
    import pci_seq_pkg::*;
#(
    parameter int         MAX_BURST = 16,
    parameter logic [3:0] PARK_CBE  = 4'b0000,
    localparam int        LEN_W     = $clog2(MAX_BURST + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    input  logic [3:0]       req_cmd,
    input  logic [3:0]       req_be_n,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_write,
    input  logic             cfg_big_endian,
    input  logic [31:0]      wr_data,
    output logic             wr_pop,
    output logic [31:0]      rd_data,
    output logic             rd_valid,
    input  logic             gnt_n,
    input  logic             devsel_n,
    input  logic             trdy_n,
    input  logic [31:0]      ad_i,
    output logic [31:0]      ad_o,
    output logic             ad_oe,
    output logic [3:0]       cbe_o,
    output logic             cbe_oe,
    output logic             par_o,
    output logic             par_oe,
    output logic             frame_o,
    output logic             frame_oe
);

    seq_st_e          st_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             accept, advance, write_q;
    xfer_t            req;

    assign req = '{addr: req_addr, cmd: req_cmd, be_n: req_be_n, write: req_write};

    pci_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst(rst), .gnt_n(gnt_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
        .req_valid(req_valid), .req_len(req_len), .req_ready(req_ready),
        .accept(accept), .advance(advance), .st_q(st_q), .st_d(st_d),
        .cnt_q(cnt_q), .cnt_d(cnt_d)
    );

    assign wr_pop = write_q && ((st_q == ST_ADDR) ||
                    (advance && (cnt_q != LEN_W'(1))));

    pci_lane_drv #(.LEN_W(LEN_W), .PARK_CBE(PARK_CBE)) u_lane (
        .clk(clk), .rst(rst), .st_d(st_d), .accept(accept), .req(req),
        .cnt_d(cnt_d), .load(wr_pop), .advance(advance), .big(cfg_big_endian),
        .wr_data(wr_data), .ad_i(ad_i), .write_q(write_q),
        .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o), .cbe_oe(cbe_oe),
        .par_o(par_o), .par_oe(par_oe), .frame_o(frame_o), .frame_oe(frame_oe),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R2: address phase is dword aligned, framed and driven
    p_addr_align_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (ad_oe && cbe_oe && frame_oe && !frame_o && ad_o[1:0] == 2'b00));
    // R4: final data phase has FRAME# high
    p_last_frame_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA && cnt_q == LEN_W'(1)) |-> (frame_oe && frame_o));
    // R7: completed read returns a word next clock
    p_rd_return_r7: assert property (@(posedge clk) disable iff (rst)
        (advance && !write_q) |=> rd_valid);
    // R9: parked bus is driven to zero without FRAME#
    p_park_drive_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PARK) |-> (ad_oe && cbe_oe && ad_o == 32'h0 && !frame_oe));
    // R10: grant removal releases the parked bus
    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PARK && gnt_n) |=> (!ad_oe && !cbe_oe));

endmodule

// File: tb/tb_pci_init_seq.sv
module tb_pci_init_seq;

    localparam int MAXB = 4;
    localparam int LW   = $clog2(MAXB + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, req_valid, req_write, cfg_big_endian;
    logic [31:0]   req_addr, wr_data, ad_i;
    logic [3:0]    req_cmd, req_be_n;
    logic [LW-1:0] req_len;
    logic          gnt_n, devsel_n, trdy_n;
    logic          req_ready, wr_pop, rd_valid, ad_oe, cbe_oe, par_o, par_oe, frame_o, frame_oe;
    logic [31:0]   rd_data, ad_o;
    logic [3:0]    cbe_o;

    pci_init_seq #(.MAX_BURST(MAXB)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_be_n(req_be_n), .req_len(req_len),
        .req_write(req_write), .cfg_big_endian(cfg_big_endian), .wr_data(wr_data),
        .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid), .gnt_n(gnt_n),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .cbe_o(cbe_o), .cbe_oe(cbe_oe), .par_o(par_o), .par_oe(par_oe),
        .frame_o(frame_o), .frame_oe(frame_oe)
    );

    int checks = 0, errors = 0, cycles = 0;
    logic [31:0] wq[$];

    // reference model state: 0 idle, 1 park, 2 address, 3 data
    int m = 0, mcnt = 0;
    logic mw = 0;
    logic [3:0] mbe = 4'hF;
    logic [31:0] e_ad = 0, e_rdd = 0;
    logic [3:0]  e_cbe = 0;
    logic e_adoe = 0, e_cbeoe = 0, e_fr = 1, e_froe = 0, e_par = 0, e_paroe = 0, e_rdv = 0;

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    function automatic logic m_ready();
        return (m <= 1) && !gnt_n;
    endfunction

    function automatic logic m_adv();
        return (m == 3) && !trdy_n && !devsel_n;
    endfunction

    function automatic logic m_pop();
        return mw && ((m == 2) || (m_adv() && mcnt > 1));
    endfunction

    task automatic release_all();
        e_adoe = 0; e_cbeoe = 0; e_froe = 0; e_fr = 1;
    endtask

    task automatic model_edge();
        logic acc, adv, pop;
        logic [31:0] word;
        acc  = m_ready() && req_valid;
        adv  = m_adv();
        pop  = m_pop();
        word = cfg_big_endian ? rev(wr_data) : wr_data;
        e_par   = ^{e_ad, e_cbe};
        e_paroe = e_adoe;
        e_rdv   = adv && !mw;
        if (adv && !mw) e_rdd = cfg_big_endian ? rev(ad_i) : ad_i;
        if (acc) begin
            m = 2; mcnt = int'(req_len); mw = req_write; mbe = req_be_n;
            e_ad = {req_addr[31:2], 2'b00}; e_cbe = req_cmd;
            e_adoe = 1; e_cbeoe = 1; e_fr = 0; e_froe = 1;
        end else if (m == 0) begin
            if (!gnt_n) begin
                m = 1; e_ad = 0; e_cbe = 4'b0000; e_adoe = 1; e_cbeoe = 1; e_froe = 0; e_fr = 1;
            end else release_all();
        end else if (m == 1) begin
            if (gnt_n) begin m = 0; release_all(); end
        end else if (m == 2) begin
            m = 3; e_cbe = mbe; e_adoe = mw; e_fr = (mcnt == 1);
            if (mw) e_ad = word;
        end else if (adv) begin
            if (mcnt == 1) begin m = 0; release_all(); end
            else begin
                mcnt--; e_fr = (mcnt == 1);
                if (mw) e_ad = word;
            end
        end
        if (pop && wq.size() > 0) void'(wq.pop_front());
    endtask

    task automatic step();
        #1;
        chk("R1 req_ready", 32'(req_ready), 32'(m_ready()));
        chk("R5 wr_pop", 32'(wr_pop), 32'(m_pop()));
        @(posedge clk);
        model_edge();
        cycles++;
        @(negedge clk);
        chk("R2/R3/R9 ad_oe", 32'(ad_oe), 32'(e_adoe));
        if (e_adoe) chk("R2/R3/R6/R9 ad_o", ad_o, e_ad);
        chk("R4/R10 cbe_oe", 32'(cbe_oe), 32'(e_cbeoe));
        if (e_cbeoe) chk("R3/R9 cbe_o", 32'(cbe_o), 32'(e_cbe));
        chk("R4 frame_oe", 32'(frame_oe), 32'(e_froe));
        if (e_froe) chk("R4 frame_o", 32'(frame_o), 32'(e_fr));
        chk("R8 par_oe", 32'(par_oe), 32'(e_paroe));
        if (e_paroe) chk("R8 par_o", 32'(par_o), 32'(e_par));
        chk("R7 rd_valid", 32'(rd_valid), 32'(e_rdv));
        if (e_rdv) chk("R6/R7 rd_data", rd_data, e_rdd);
        wr_data = (wq.size() > 0) ? wq[0] : 32'hDEAD_0000;
    endtask

    task automatic issue(input logic [31:0] a, input logic [3:0] c, input logic [3:0] be,
                         input int len, input logic w);
        req_valid = 1; req_addr = a; req_cmd = c; req_be_n = be;
        req_len = LW'(len); req_write = w;
    endtask

    initial begin
        rst = 1; req_valid = 0; req_addr = 0; req_cmd = 0; req_be_n = 4'hF; req_len = '0;
        req_write = 0; cfg_big_endian = 0; wr_data = 0; ad_i = 0;
        gnt_n = 1; devsel_n = 1; trdy_n = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 ad_oe", 32'(ad_oe), 0);
        chk("R11 frame", {30'd0, frame_oe, frame_o}, 32'd1);
        chk("R11 rd_valid", 32'(rd_valid), 0);
        rst = 0;
        step();

        // R9/R10: park then release
        gnt_n = 0;
        repeat (3) step();
        gnt_n = 1;
        repeat (2) step();

        // R2/R3/R5: little-endian write burst at full length with waits
        wq = '{32'h11223344, 32'h55667788, 32'h99AABBCC, 32'hDDEEFF01};
        wr_data = wq[0];
        gnt_n = 0;
        issue(32'h1000_0007, 4'h7, 4'b0000, MAXB, 1);
        step();
        req_valid = 0;
        devsel_n = 0;
        for (int i = 0; i < 12; i++) begin
            trdy_n = (i % 3 == 1);
            if (i == 5) devsel_n = 1; else devsel_n = 0;
            step();
        end
        trdy_n = 1; gnt_n = 1;
        repeat (3) step();

        // R6/R7: big-endian read burst of three
        cfg_big_endian = 1; gnt_n = 0;
        issue(32'hABCD_0102, 4'h6, 4'b1010, 3, 0);
        step();
        req_valid = 0;
        for (int i = 0; i < 8; i++) begin
            ad_i = 32'h0102_0304 + 32'(i) * 32'h1111_1111;
            trdy_n = (i == 2); devsel_n = 0;
            step();
        end
        trdy_n = 1;

        // R9: request accepted straight from park; single big-endian write
        repeat (2) step();
        wq = '{32'hCAFE_BABE};
        wr_data = wq[0];
        issue(32'h0000_0FFC, 4'h7, 4'b1100, 1, 1);
        step();
        req_valid = 0;
        trdy_n = 0;
        repeat (3) step();
        trdy_n = 1;

        // R6: little-endian single read
        cfg_big_endian = 0;
        issue(32'h2000_0001, 4'h6, 4'b0111, 1, 0);
        step();
        req_valid = 0;
        ad_i = 32'hF00D_1234; trdy_n = 0;
        repeat (3) step();
        trdy_n = 1; gnt_n = 1;
        repeat (3) step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule